// File: doc/BRIEF.md
# Token Ring Node Controller

This block owns one end of a two-node token ring that paces the data channels between two locally clocked blocks. The token is carried by transition signalling: each toggle of the incoming line is one token arrival, whatever its level. While the node holds the token it enables the local ends of the channels. A hold countdown decides when the token is sent back to the far node. A recycle countdown then decides the earliest local cycle on which a returning token is accepted. A token that returns early is latched and waits for that cycle. A token that returns late freezes the local block by dropping the block clock enable.

The block runs on the local clock. The clock enables of all nodes in one block are combined by an AND outside this block, so one late ring is enough to stop the block. Restart is modelled as a token toggle seen while the enable is low: the enable comes back at once and the node starts a new hold on the next cycle. Hold and recycle lengths come from two writable registers. A parameter picks which node starts with the token. A second parameter gives the reset phase of the incoming line, so an inverting link in the ring does not look like a token at start-up.

Top module: `tring_node`

## Requirements
- R1: After reset, `tok_out` is 0 and `blk_en` is 1. `chan_en` is 1 when the parameter INIT_HOLDER is 1 and 0 when it is 0.
- R2: After a hold count H is loaded, `chan_en` stays high for exactly H+1 cycles; H=0 gives one cycle. `tok_out` toggles on the same edge on which `chan_en` falls.
- R3: A token toggle seen during the R+1 recycle cycles after a pass (R is the loaded recycle count) is kept pending and not acted on early. `chan_en` rises in cycle R+2 after the pass edge, whichever of those cycles the toggle came in.
- R4: `blk_en` stays high during recycle. If no toggle has been seen by the end of recycle, `blk_en` is low from cycle R+2 after the pass until the cycle in which a toggle arrives. `chan_en` is never high while `blk_en` is low.
- R5: While stalled, `blk_en` goes high in the same cycle in which the `tok_in` toggle is visible. `chan_en` rises on the next cycle with a fresh hold count, so a stall ending in cycle j gives a gap of exactly j cycles.
- R6: A token is a change of `tok_in` from its last seen value. A rising change and a falling change both count.
- R7: A pulse on `hold_wr` or `recyc_wr` stores `cfg_data` in that register. The stored value is used at the next load of the counter and does not change a countdown in progress. The reset values are HOLD_INIT and RECYC_INIT.
- R8: The stored phase of `tok_in` resets to the parameter TOK_IN_RST. A `tok_in` held at that level is never taken as a token, so a node without the token stalls after its first recycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_wr | input | 1 | Write strobe for the hold-length register |
| recyc_wr | input | 1 | Write strobe for the recycle-length register |
| cfg_data | input | CNT_W | Value written by either strobe |
| tok_in | input | 1 | Incoming token line (transition signalled) |
| tok_out | output | 1 | Outgoing token line (toggles on each pass) |
| chan_en | output | 1 | Channel clock enable, high while the token is held |
| blk_en | output | 1 | Block clock enable, low while waiting for a late token |

## Verification
A table of hold length, recycle length and token return cycle drives the main loop. It includes a toggle in the first recycle cycle, a toggle in the last recycle cycle, and a toggle one cycle past the end of recycle. It also includes long stalls and zero hold and zero recycle counts. Comparing the measured gap with R+1 separates early tokens that are wrongly acted on from tokens that are correctly held back. Comparing the stall length with j-R-2 shows whether the freeze starts and ends on the right cycle. Directed cases cover a falling-edge token, the reset level on the non-holding node, and a register write during a hold that must not shorten it.

// File: rtl/tring_pkg.sv
package tring_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_RECYC = 2'd1,
        ST_STALL = 2'd2
    } node_st_e;

    typedef struct packed {
        logic load;
        logic dec;
    } cnt_ctl_t;

    function automatic node_st_e after_recycle(input logic tok_any);
        return tok_any ? ST_HOLD : ST_STALL;
    endfunction

endpackage

// File: rtl/tring_cfg_reg.sv
module tring_cfg_reg #(
    parameter int          W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)       q_o <= W'(RST_VAL);
        else if (we_i) q_o <= wdata_i;
    end
endmodule

// File: rtl/tring_countdown.sv
module tring_countdown
    import tring_pkg::*;
#(
    parameter int          CNT_W   = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctl_t         ctl_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= CNT_W'(RST_VAL);
        else if (ctl_i.load)
            cnt_q <= load_val_i;
        else if (ctl_i.dec && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign zero_o = (cnt_q == '0);

    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.dec && !ctl_i.load && !zero_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R3
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_o && !ctl_i.load) |=> zero_o);

    // R7
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_i.load |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/tring_tok_detect.sv
module tring_tok_detect #(
    parameter bit RST_PHASE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic tok_i,
    input  logic clr_i,
    output logic any_o
);
    logic seen_q;
    logic pend_q;
    logic arrive;

    assign arrive = tok_i ^ seen_q;
    assign any_o  = pend_q | arrive;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= RST_PHASE;
            pend_q <= 1'b0;
        end else begin
            seen_q <= tok_i;
            pend_q <= clr_i ? 1'b0 : (pend_q | arrive);
        end
    end

    // R3
    pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr_i) |=> pend_q);

    // R6
    toggle_seen_chk: assert property (@(posedge clk) disable iff (rst)
        (tok_i != $past(tok_i)) |-> any_o);
endmodule

// File: rtl/tring_node.sv
module tring_node
    import tring_pkg::*;
#(
    parameter int          CNT_W       = 8,
    parameter bit          INIT_HOLDER = 1'b1,
    parameter int unsigned HOLD_INIT   = 3,
    parameter int unsigned RECYC_INIT  = 4,
    parameter bit          TOK_IN_RST  = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_wr,
    input  logic             recyc_wr,
    input  logic [CNT_W-1:0] cfg_data,
    input  logic             tok_in,
    output logic             tok_out,
    output logic             chan_en,
    output logic             blk_en
);
    localparam node_st_e RST_ST = INIT_HOLDER ? ST_HOLD : ST_RECYC;

    node_st_e         st_q, st_d;
    logic [CNT_W-1:0] hold_len, recyc_len;
    logic             hold_zero, recyc_zero, tok_any, enter_hold, pass_now;
    cnt_ctl_t         hold_ctl, recyc_ctl;

    tring_cfg_reg #(.W(CNT_W), .RST_VAL(HOLD_INIT)) u_hold_reg (
        .clk(clk), .rst(rst), .we_i(hold_wr), .wdata_i(cfg_data), .q_o(hold_len));

    tring_cfg_reg #(.W(CNT_W), .RST_VAL(RECYC_INIT)) u_recyc_reg (
        .clk(clk), .rst(rst), .we_i(recyc_wr), .wdata_i(cfg_data), .q_o(recyc_len));

    tring_tok_detect #(.RST_PHASE(TOK_IN_RST)) u_detect (
        .clk(clk), .rst(rst), .tok_i(tok_in), .clr_i(enter_hold), .any_o(tok_any));

    tring_countdown #(.CNT_W(CNT_W), .RST_VAL(HOLD_INIT)) u_hold_cnt (
        .clk(clk), .rst(rst), .ctl_i(hold_ctl), .load_val_i(hold_len), .zero_o(hold_zero));

    tring_countdown #(.CNT_W(CNT_W), .RST_VAL(RECYC_INIT)) u_recyc_cnt (
        .clk(clk), .rst(rst), .ctl_i(recyc_ctl), .load_val_i(recyc_len), .zero_o(recyc_zero));

    assign pass_now   = (st_q == ST_HOLD) && hold_zero;
    assign enter_hold = tok_any && ((st_q == ST_STALL) || (st_q == ST_RECYC && recyc_zero));

    assign hold_ctl   = '{load: enter_hold, dec: (st_q == ST_HOLD)};
    assign recyc_ctl  = '{load: pass_now,   dec: (st_q == ST_RECYC)};

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HOLD:  if (hold_zero)  st_d = ST_RECYC;
            ST_RECYC: if (recyc_zero) st_d = after_recycle(tok_any);
            ST_STALL: if (tok_any)    st_d = ST_HOLD;
            default:                  st_d = RST_ST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= RST_ST;
            tok_out <= 1'b0;
        end else begin
            st_q <= st_d;
            if (pass_now) tok_out <= ~tok_out;
        end
    end

    assign chan_en = (st_q == ST_HOLD);
    assign blk_en  = (st_q != ST_STALL) || tok_any;

    // R2
    pass_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(tok_out) |-> ($past(chan_en) && !chan_en));

    // R4
    frozen_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !blk_en |-> !chan_en);

    // R5
    wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!chan_en && blk_en && $past(!blk_en) && tok_any) |=> chan_en);

    // R1
    reset_tok_chk: assert property (@(posedge clk)
        $past(rst) |-> (tok_out == 1'b0));
endmodule

// File: tb/sim_tring_node.sv
`timescale 1ns/1ps
module sim_tring_node;
    localparam int CW = 8;
    localparam int NV = 7;
    // {hold, recycle, token return cycle after pass}
    localparam int VEC [NV][3] = '{
        '{2, 5, 1}, '{2, 5, 6}, '{0, 3, 4}, '{1, 3, 5},
        '{4, 2, 9}, '{0, 0, 1}, '{6, 1, 3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_wr = 1'b0, recyc_wr = 1'b0;
    logic [CW-1:0] cfg_data = '0;
    logic tok_in = 1'b0, tok_in1 = 1'b1;
    logic tok_out, chan_en, blk_en;
    logic tok_out1, chan_en1, blk_en1;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tring_node #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .hold_wr(hold_wr), .recyc_wr(recyc_wr),
        .cfg_data(cfg_data), .tok_in(tok_in), .tok_out(tok_out),
        .chan_en(chan_en), .blk_en(blk_en));

    tring_node #(.CNT_W(CW), .INIT_HOLDER(1'b0), .TOK_IN_RST(1'b1)) u1 (
        .clk(clk), .rst(rst), .hold_wr(1'b0), .recyc_wr(1'b0),
        .cfg_data('0), .tok_in(tok_in1), .tok_out(tok_out1),
        .chan_en(chan_en1), .blk_en(blk_en1));

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(); tick(); rst = 1'b0;
    endtask

    initial begin
        int h, r, j, k, gap, stall, hl, e_gap, e_stall;
        do_reset();
        // R1 reset state of both nodes
        chk(chan_en == 1'b1, "R1 holder chan_en", chan_en, 1);
        chk(blk_en == 1'b1 && tok_out == 1'b0, "R1 holder blk_en/tok_out", {blk_en, tok_out}, 2);
        chk(chan_en1 == 1'b0 && blk_en1 == 1'b1, "R1 idle node enables", {chan_en1, blk_en1}, 1);
        // R8: static level equal to TOK_IN_RST is no token; stall after RECYC_INIT+1 cycles
        for (int c = 0; c < 10; c++) tick();
        chk(blk_en1 == 1'b0 && chan_en1 == 1'b0, "R8 idle node stalls", {blk_en1, chan_en1}, 0);
        // R5: wake in the toggle cycle, hold next cycle for HOLD_INIT+1
        tok_in1 = 1'b0; #1;
        chk(blk_en1 == 1'b1, "R5 wake same cycle", blk_en1, 1);
        tick();
        chk(chan_en1 == 1'b1, "R5 hold next cycle", chan_en1, 1);
        hl = 0;
        while (chan_en1 && hl < 50) begin hl++; tick(); end
        chk(hl == 4, "R5 reloaded hold length", hl, 4);
        chk(tok_out1 == 1'b1, "R2 idle node passes", tok_out1, 1);

        for (int v = 0; v < NV; v++) begin
            h = VEC[v][0]; r = VEC[v][1]; j = VEC[v][2];
            tok_in = 1'b0;
            do_reset();
            hold_wr = 1'b1; cfg_data = CW'(h); tick();
            hold_wr = 1'b0; recyc_wr = 1'b1; cfg_data = CW'(r); tick();
            recyc_wr = 1'b0; tick();
            // R7: write during the first hold keeps HOLD_INIT+1 = 4 cycles
            chk(chan_en == 1'b1, "R7 hold not shortened by write", chan_en, 1);
            tick();
            chk(chan_en == 1'b0 && tok_out == 1'b1, "R2 pass after 4 cycles", {chan_en, tok_out}, 1);
            k = 1; gap = 0; stall = 0;
            while (k < 300) begin
                if (k == j) begin tok_in = ~tok_in; #1; end
                if (chan_en) break;
                gap++;
                if (!blk_en) stall++;
                if (k == j && j > r + 1)
                    chk(blk_en == 1'b1, "R5 blk_en up in toggle cycle", blk_en, 1);
                tick(); k++;
            end
            e_gap   = (j <= r + 1) ? r + 1 : j;
            e_stall = (j > r + 1) ? j - r - 2 : 0;
            chk(gap == e_gap, (j <= r + 1) ? "R3 early token gap" : "R5 late token gap", gap, e_gap);
            chk(stall == e_stall, "R4 stall cycles", stall, e_stall);
            hl = 0;
            while (chan_en && hl < 300) begin hl++; tick(); end
            chk(hl == h + 1, "R2 hold length", hl, h + 1);
            chk(tok_out == 1'b0, "R2 second pass toggles back", tok_out, 0);
        end

        // R6: falling toggle in first recycle cycle, recycle of last vector is 1
        tok_in = 1'b0; #1;
        gap = 0;
        while (!chan_en && gap < 50) begin gap++; tick(); end
        chk(gap == 2, "R6 falling toggle accepted", gap, 2);
        // R4: blk_en high throughout the recycle without token
        while (chan_en) tick();
        stall = 0;
        for (int c = 0; c < 2; c++) begin
            if (!blk_en) stall++;
            tick();
        end
        chk(stall == 0, "R4 blk_en high in recycle", stall, 0);
        chk(blk_en == 1'b0, "R4 stall after recycle", blk_en, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule